// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus. The bus has an address, a write strobe, write data and a combinational read data path. A free-running base tick, normally one pulse per microsecond, enters a programmable prescaler. The prescaler turns the base tick into a slower count tick, and each count tick lowers a 16-bit down-counter. Software arms the counter by writing a restart command, which copies the load register into the counter.

If software stops restarting the counter while the watchdog is enabled, the counter runs out. The block then raises a reset request for one clock, sets a sticky cause flag and reloads the counter. After the system restarts, software reads the cause flag to learn that the watchdog caused the reset, then clears it with a write-one. A safe stop is a restart followed by a write that clears the enable bit.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the control word reads 0x00000000, the load word reads 0x0000FFFF, the status word reads 0xFFFF0000 (counter 0xFFFF, cause 0) and `rstReq` is low.
- R2: The address map has three words. Status is at 0x00 and shows the live counter in [31:16] and the cause flag in bit 1. Control is at 0x20, with enable in bit 7 and the divider in [31:16]. Load is at 0x24, in [15:0]. Control and load read back what was written.
- R3: A write to the load word leaves the counter unchanged until a restart is issued.
- R4: A status write with bit 9 set copies the load value into the counter and clears the prescaler. It takes priority over a count tick in the same cycle.
- R5: While enable is 0, the counter and the prescaler hold their values and `rstReq` stays low.
- R6: While enabled, the prescaler advances only on cycles where `usTick` is high. A count tick occurs every d base ticks, where d is the divider field and 0 acts as 1. After a restart, the first `rstReq` rises (load+1)·d base ticks after enabling.
- R7: Expiry raises `rstReq` for exactly one clock and reloads the counter from the load word, so an unattended watchdog pulses every (load+1)·d base ticks.
- R8: Expiry sets the cause flag. A status write with bit 1 set clears it. A status write with bit 1 clear leaves it unchanged. If an expiry and a clear fall in the same cycle, the set wins.
- R9: Restarts that arrive more often than the timeout prevent any expiry.
- R10: A restart followed by clearing enable produces no expiry, and the counter then holds.
- R11: Reads of any other address return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| usTick | input | 1 | Base tick, one clock wide |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` (combinational) |
| rstReq | output | 1 | One-clock reset request on expiry |

## Verification
The main timeout is measured as the number of cycles from the enable write to the rising edge of `rstReq`. It is measured for several cases:
- Divider 1 and divider 3: these separate count-tick spacing from counter depth.
- Divider 0: this shows whether zero is mapped to divide-by-1.
- The base tick held low and then released: this shows whether the prescaler is gated by the tick.

The interval between two unattended pulses checks that the counter reloads. Frequent restarts, a safe stop and a write to the load word with no restart each must leave the timeout unchanged or suppress it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DataW = 32;
  localparam int CntW  = 16;
  localparam int DivW  = 16;
  localparam int AddrW = 8;

  localparam logic [AddrW-1:0] OffStatus = 8'h00;
  localparam logic [AddrW-1:0] OffCtrl   = 8'h20;
  localparam logic [AddrW-1:0] OffLoad   = 8'h24;

  localparam int EnBit      = 7;
  localparam int RestartBit = 9;
  localparam int CauseBit   = 1;
  localparam int HighLsb    = 16;

  typedef struct packed {
    logic            restart;
    logic            clrCause;
    logic            en;
    logic [DivW-1:0] divVal;
    logic [CntW-1:0] loadVal;
  } wdogCmd_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWrEn,
  input  logic [DataW-1:0] busWrData,
  input  logic             causeFlag,
  input  logic [CntW-1:0]  count,
  output logic [DataW-1:0] busRdData,
  output wdogCmd_t         cmd
);
  logic            selStatus, selCtrl, selLoad;
  logic            enReg;
  logic [DivW-1:0] divReg;
  logic [CntW-1:0] loadReg;

  assign selStatus = (busAddr == OffStatus);
  assign selCtrl   = (busAddr == OffCtrl);
  assign selLoad   = (busAddr == OffLoad);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      divReg  <= '0;
      loadReg <= '1;
    end else if (busWrEn) begin
      if (selCtrl) begin
        enReg  <= busWrData[EnBit];
        divReg <= busWrData[HighLsb +: DivW];
      end
      if (selLoad) loadReg <= busWrData[CntW-1:0];
    end
  end

  always_comb begin
    cmd.restart  = busWrEn && selStatus && busWrData[RestartBit];
    cmd.clrCause = busWrEn && selStatus && busWrData[CauseBit];
    cmd.en       = enReg;
    cmd.divVal   = divReg;
    cmd.loadVal  = loadReg;
  end

  always_comb begin
    busRdData = '0;
    if (selStatus) begin
      busRdData[HighLsb +: CntW] = count;
      busRdData[CauseBit]        = causeFlag;
    end else if (selCtrl) begin
      busRdData[HighLsb +: DivW] = divReg;
      busRdData[EnBit]           = enReg;
    end else if (selLoad) begin
      busRdData[CntW-1:0] = loadReg;
    end
  end
endmodule

// File: rtl/wdog_dpath.sv
module wdog_dpath
  import wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            usTick,
  input  wdogCmd_t        cmd,
  output logic [CntW-1:0] count,
  output logic            causeFlag,
  output logic            rstReq
);
  logic [DivW-1:0] preCnt;
  logic [DivW-1:0] divEff;
  logic            preWrap, cntTick, expire;

  assign divEff  = (cmd.divVal == '0) ? DivW'(1) : cmd.divVal;
  assign preWrap = (preCnt >= divEff - DivW'(1));
  assign cntTick = cmd.en && usTick && preWrap && !cmd.restart;
  assign expire  = cntTick && (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     preCnt <= '0;
    else if (cmd.restart)          preCnt <= '0;
    else if (cmd.en && usTick)     preCnt <= preWrap ? '0 : preCnt + DivW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '1;
    else if (cmd.restart)  count <= cmd.loadVal;
    else if (cntTick)      count <= (count == '0) ? cmd.loadVal : count - CntW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeFlag <= 1'b0;
      rstReq    <= 1'b0;
    end else begin
      rstReq <= expire;
      if (expire)            causeFlag <= 1'b1;
      else if (cmd.clrCause) causeFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWrEn,
  input  logic [DataW-1:0] busWrData,
  output logic [DataW-1:0] busRdData,
  output logic             rstReq
);
  wdogCmd_t        cmd;
  logic [CntW-1:0] count;
  logic            causeFlag;

  wdog_regs u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .causeFlag(causeFlag), .count(count),
    .busRdData(busRdData), .cmd(cmd)
  );

  wdog_dpath u_dpath (
    .clk(clk), .rstN(rstN), .usTick(usTick), .cmd(cmd),
    .count(count), .causeFlag(causeFlag), .rstReq(rstReq)
  );
endmodule

// File: rtl/wdog_checks.sv
module wdog_checks
  import wdog_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            rstReq,
  input logic            causeFlag,
  input logic [CntW-1:0] count,
  input wdogCmd_t        cmd
);
  p_cause_on_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> causeFlag);

  p_cause_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (causeFlag && !cmd.clrCause) |=> causeFlag);

  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.en && !cmd.restart) |=> (count == $past(count)));

  p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.en |=> !rstReq);

  p_restart_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (count == $past(cmd.loadVal)));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq && count != '0) |=> !rstReq);

  p_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.restart && count != '0) |=>
      (count == $past(count) || count == $past(count) - CntW'(1)));
endmodule

bind tick_watchdog wdog_checks u_chk (
  .clk(clk), .rstN(rstN), .rstReq(rstReq), .causeFlag(causeFlag),
  .count(count), .cmd(cmd)
);

// File: tb/tick_watchdog_tb.sv
module tick_watchdog_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usTick = 1'b1;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        rstReq;

  int compared = 0;
  int mism = 0;
  int cyc = 0;
  int wrCyc = 0;
  int pulses = 0;
  int adjacent = 0;
  int lastRise = 0;
  int prevRise = 0;
  logic prevReq = 1'b0;
  bit done = 0;

  logic [31:0] expQ[$];
  logic [31:0] maskQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  tick_watchdog u_dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .rstReq(rstReq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstReq) begin
      if (prevReq) adjacent++;
      else begin
        pulses++;
        prevRise = lastRise;
        lastRise = cyc;
      end
    end
    prevReq = rstReq;
  end

  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [31:0] e, m;
      string t;
      e = expQ.pop_front();
      m = maskQ.pop_front();
      t = tagQ.pop_front();
      compared++;
      if ((busRdData & m) !== (e & m)) begin
        mism++;
        $display("FAIL %s: read %h expected %h (mask %h)", t, busRdData, e, m);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mism++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    wrCyc = cyc;
    busWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, input logic [31:0] e,
                         input logic [31:0] m, input string tag);
    @(posedge clk); #1;
    busAddr = a; busWrEn = 1'b0;
    expQ.push_back(e); maskQ.push_back(m); tagQ.push_back(tag);
  endtask

  task automatic waitPulses(input int n);
    for (int g = 0; g < 2000 && pulses < n; g++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic stopDog();
    regWrite(8'h00, 32'h200);
    regWrite(8'h20, 32'h0001_0000);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      mism++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
      $finish;
    end
  end

  initial begin
    int base, t0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    check(rstReq == 1'b0, "R1 rstReq", int'(rstReq), 0);
    regRead(8'h20, 32'h0, '1, "R1 ctrl");
    regRead(8'h24, 32'h0000_FFFF, '1, "R1 load");
    regRead(8'h00, 32'hFFFF_0000, '1, "R1 status");

    // R11 unmapped
    regWrite(8'h10, 32'hFFFF_FFFF);
    regRead(8'h10, 32'h0, '1, "R11 unmapped read");
    regRead(8'h2C, 32'h0, '1, "R11 unmapped read 2");
    regRead(8'h20, 32'h0, '1, "R11 ctrl untouched");
    regRead(8'h24, 32'h0000_FFFF, '1, "R11 load untouched");

    // R3 load write does not restart; R2 readback
    regWrite(8'h24, 32'h5);
    regRead(8'h24, 32'h5, '1, "R2 load readback");
    regRead(8'h00, 32'hFFFF_0000, '1, "R3 no restart on load");

    // R4 restart
    regWrite(8'h00, 32'h200);
    regRead(8'h00, 32'h0005_0000, '1, "R4 restart loads");

    // R5 hold while disabled
    repeat (10) @(posedge clk);
    regRead(8'h00, 32'h0005_0000, '1, "R5 hold");
    check(pulses == 0, "R5 no pulse", pulses, 0);

    // R6 divider 1
    regWrite(8'h20, 32'h0001_0080);
    t0 = wrCyc;
    regRead(8'h20, 32'h0001_0080, '1, "R2 ctrl readback");
    waitPulses(1);
    check(lastRise - t0 == 6, "R6 div1 timeout", lastRise - t0, 6);
    regRead(8'h00, 32'h2, 32'h2, "R8 cause set");
    waitPulses(2);
    check(lastRise - prevRise == 6, "R7 reload period", lastRise - prevRise, 6);
    check(adjacent == 0, "R7 one-cycle pulse", adjacent, 0);

    // R10 safe disable
    stopDog();
    base = pulses;
    repeat (40) @(posedge clk);
    check(pulses == base, "R10 no expiry", pulses, base);
    regRead(8'h00, 32'h0003_0000, 32'hFFFF_0000, "R10 count holds");

    // R8 clear behaviour
    regWrite(8'h00, 32'h0);
    regRead(8'h00, 32'h2, 32'h2, "R8 cause kept");
    regWrite(8'h00, 32'h2);
    regRead(8'h00, 32'h0, 32'h2, "R8 cause cleared");

    // R6 divider 3, load 2
    regWrite(8'h24, 32'h2);
    regWrite(8'h00, 32'h200);
    base = pulses;
    regWrite(8'h20, 32'h0003_0080);
    t0 = wrCyc;
    waitPulses(base + 1);
    check(lastRise - t0 == 9, "R6 div3 timeout", lastRise - t0, 9);
    stopDog();

    // R6 divider 0 acts as 1, load 3
    regWrite(8'h24, 32'h3);
    regWrite(8'h00, 32'h200);
    base = pulses;
    regWrite(8'h20, 32'h0000_0080);
    t0 = wrCyc;
    waitPulses(base + 1);
    check(lastRise - t0 == 4, "R6 div0 timeout", lastRise - t0, 4);
    stopDog();

    // R6 base tick gating
    regWrite(8'h24, 32'h2);
    regWrite(8'h00, 32'h200);
    @(posedge clk); #1 usTick = 1'b0;
    base = pulses;
    regWrite(8'h20, 32'h0001_0080);
    repeat (20) @(posedge clk);
    regRead(8'h00, 32'h0002_0000, 32'hFFFF_0000, "R6 no tick no count");
    check(pulses == base, "R6 gated no pulse", pulses, base);
    @(posedge clk); #1 usTick = 1'b1; t0 = cyc;
    waitPulses(base + 1);
    check(lastRise - t0 == 3, "R6 tick release timeout", lastRise - t0, 3);
    stopDog();

    // R9 keep-alive
    regWrite(8'h24, 32'h4);
    regWrite(8'h00, 32'h200);
    base = pulses;
    regWrite(8'h20, 32'h0001_0080);
    for (int i = 0; i < 20; i++) regWrite(8'h00, 32'h200);
    check(pulses == base, "R9 keep-alive", pulses, base);
    stopDog();
    regRead(8'h20, 32'h0001_0000, '1, "R2 enable cleared");

    repeat (3) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end
endmodule